// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds two independent 32-bit down counters behind one word-addressed register bus. Each counter owns six consecutive register words, its own control bits and its own interrupt line. A counter counts down by one per clock while running. When it is running and reaches zero it raises a raw interrupt flag. In periodic mode it then reloads and keeps going. In one-shot mode it stops at zero.

Software programs a counter through a foreground load value, which restarts the count at once when written while the counter is enabled. It can also use a background load value, which changes the reload value without touching the count in progress. The raw flag is cleared by writing 1 to it. The masked status and the interrupt line both show the raw flag gated by the interrupt-enable bit. Reads return data one clock after the read strobe. The word range above the two register sets is reserved: it reads as zero and ignores writes.

Top module: `dual_interval_timer`

## Requirements
- R1: After synchronous reset every register reads zero, both counters are stopped and both `irq` bits are low.
- R2: The word index is `bus_addr[7:2]`. Words 0 to 5 belong to counter 0 and words 6 to 11 belong to counter 1. Within a set, the offsets are 0 for the live count, 1 for the load value, 2 for the background load, 3 for control, 4 for the raw flag and 5 for the masked status. Words 12 and up read as zero and ignore writes. `bus_rdata` is updated on the clock edge that samples `bus_rd`.
- R3: Control bit 0 is enable, bit 1 is one-shot and bit 2 is interrupt enable. Reading control returns these three bits, with all upper bits zero.
- R4: Writing control with bit 0 set loads the count from the current load value and starts counting. Writing it with bit 0 clear stops the counter and holds the count. In the same cycle, a write takes priority over the count step.
- R5: While running, the count falls by exactly one each clock.
- R6: When a running counter is at zero, the raw flag (bit 0) is set in that clock edge. In periodic mode the count is loaded with the load value on the same edge.
- R7: In one-shot mode, expiry sets the raw flag and stops the counter at zero. No further expiry follows.
- R8: Writing the load value while enabled restarts the count from the new value on the next edge. While disabled, the write only stores the value.
- R9: Writing the background load stores the value into both the background and the load registers. The count in progress is not disturbed, and the next reload uses the new value.
- R10: Writing 1 to bit 0 of the raw flag clears it. Writing 0 has no effect. An expiry in the same cycle wins over the clear.
- R11: The masked status word and the counter's `irq` bit both equal the raw flag AND the interrupt-enable bit.
- R12: Writes to the live-count and masked-status words are ignored. A read of the live count returns the count held at the sampling edge.
- R13: Accesses to one counter never change the other counter's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address; the low two bits are ignored |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 2 | Interrupt line of each counter |

## Verification
A wrong count, a wrong reload value or a missed stop shows up in the very next read of the live-count word. Because every later expiry then moves as well, the raw flag and `irq` drift away from their expected cycle within a few counts. A wrong raw flag or a wrong enable bit shows on `irq` in the cycle right after the faulty edge. The bench therefore compares `irq` on every clock and compares every read against a cycle-by-cycle model. It runs long random sequences with small load values, so that expiries, restarts and clears often land in the same cycle.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int WORD_W      = 32;
    localparam int REGS_PER_CH = 6;
    localparam int OFF_W       = 3;

    // Word order inside one counter's register set.
    typedef enum logic [OFF_W-1:0] {
        OFF_VALUE  = 3'd0,
        OFF_LOAD   = 3'd1,
        OFF_BGLOAD = 3'd2,
        OFF_CTRL   = 3'd3,
        OFF_RAW    = 3'd4,
        OFF_MASKED = 3'd5
    } reg_off_e;

    typedef struct packed {
        logic irq_en;
        logic oneshot;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic              wr;
        reg_off_e          off;
        logic [WORD_W-1:0] wdata;
    } ch_req_t;

    function automatic logic [WORD_W-1:0] widen_ctrl(ctrl_t c);
        return {{(WORD_W-3){1'b0}}, c};
    endfunction

    function automatic logic [WORD_W-1:0] widen_bit(logic b);
        return {{(WORD_W-1){1'b0}}, b};
    endfunction
endpackage

// File: rtl/dit_addr_dec.sv
module dit_addr_dec
    import dit_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [NUM_CH-1:0] sel,
    output ch_req_t           req [NUM_CH]
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W:0] idx_ext;
    assign idx_ext = {1'b0, addr[ADDR_W-1:2]};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [IDX_W:0] LO = (IDX_W+1)'(c * REGS_PER_CH);
        localparam logic [IDX_W:0] HI = (IDX_W+1)'((c + 1) * REGS_PER_CH);
        logic [IDX_W:0] rel;
        assign rel          = idx_ext - LO;
        assign sel[c]       = (idx_ext >= LO) && (idx_ext < HI);
        assign req[c].wr    = wr && sel[c];
        assign req[c].off   = reg_off_e'(rel[OFF_W-1:0]);
        assign req[c].wdata = wdata;
    end
endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] start_val,
    input  logic         stop,
    input  logic         oneshot,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         expire,
    output logic         running
);
    logic [W-1:0] cnt_q;
    logic         run_q;

    assign expire  = run_q && (cnt_q == '0);
    assign count   = cnt_q;
    assign running = run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= start_val;
            run_q <= 1'b1;
        end else if (stop) begin
            run_q <= 1'b0;
        end else if (expire) begin
            if (oneshot) run_q <= 1'b0;
            else         cnt_q <= reload_val;
        end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R5
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_q != '0 && !start && !stop) |=> cnt_q == $past(cnt_q) - 1'b1);
    // R6
    periodic_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && !oneshot && !start && !stop) |=> (run_q && cnt_q == $past(reload_val)));
    // R7
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && oneshot && !start) |=> (!run_q && cnt_q == '0));
    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/dit_channel.sv
module dit_channel
    import dit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ch_req_t           req,
    output logic [WORD_W-1:0] rd_word,
    output logic              irq
);
    logic [WORD_W-1:0] load_q, bg_q, count;
    ctrl_t             ctrl_q;
    logic              raw_q, expire, running;
    logic              wr_ctrl, wr_load, wr_bg, raw_clr;
    logic              start, stop;
    logic [WORD_W-1:0] start_val;

    assign wr_ctrl = req.wr && (req.off == OFF_CTRL);
    assign wr_load = req.wr && (req.off == OFF_LOAD);
    assign wr_bg   = req.wr && (req.off == OFF_BGLOAD);
    assign raw_clr = req.wr && (req.off == OFF_RAW) && req.wdata[0];

    assign start     = (wr_ctrl && req.wdata[0]) || (wr_load && ctrl_q.enable);
    assign stop      = wr_ctrl && !req.wdata[0];
    assign start_val = wr_ctrl ? load_q : req.wdata;

    dit_counter #(.W(WORD_W)) i_counter (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_val  (start_val),
        .stop       (stop),
        .oneshot    (ctrl_q.oneshot),
        .reload_val (load_q),
        .count      (count),
        .expire     (expire),
        .running    (running)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            bg_q   <= '0;
            ctrl_q <= '0;
            raw_q  <= 1'b0;
        end else begin
            if (wr_load) load_q <= req.wdata;
            if (wr_bg) begin
                bg_q   <= req.wdata;
                load_q <= req.wdata;
            end
            if (wr_ctrl) ctrl_q <= ctrl_t'(req.wdata[2:0]);
            if (expire)       raw_q <= 1'b1;
            else if (raw_clr) raw_q <= 1'b0;
        end
    end

    assign irq = raw_q && ctrl_q.irq_en;

    always_comb begin
        case (req.off)
            OFF_VALUE:  rd_word = count;
            OFF_LOAD:   rd_word = load_q;
            OFF_BGLOAD: rd_word = bg_q;
            OFF_CTRL:   rd_word = widen_ctrl(ctrl_q);
            OFF_RAW:    rd_word = widen_bit(raw_q);
            OFF_MASKED: rd_word = widen_bit(irq);
            default:    rd_word = '0;
        endcase
    end

    // R6
    raw_set_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> raw_q);
    // R10
    raw_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (raw_q && !raw_clr) |=> raw_q);
    // R9
    bg_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        wr_bg |=> (load_q == bg_q));
    // R7
    oneshot_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !start) |=> !expire);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0] sel;
    ch_req_t           req     [NUM_CH];
    logic [WORD_W-1:0] ch_word [NUM_CH];
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rdata_q;

    dit_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_dec (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .sel   (sel),
        .req   (req)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dit_channel i_ch (
            .clk     (clk),
            .rst     (rst),
            .req     (req[c]),
            .rd_word (ch_word[c]),
            .irq     (irq[c])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel[c]) rd_mux = rd_mux | ch_word[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R2
    reserved_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == '0) |=> bus_rdata == '0);
    // R13
    single_select_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
endmodule

// File: tb/test_dual_interval_timer.sv
module test_dual_interval_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    // reference model state
    logic [31:0] m_cnt [2];
    logic [31:0] m_load [2];
    logic [31:0] m_bg [2];
    logic [2:0]  m_ctrl [2];
    logic        m_raw [2];
    logic        m_run [2];

    dual_interval_timer i_dual_interval_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] adr(int ch, int off);
        return 8'((ch * 6 + off) * 4);
    endfunction

    function automatic logic [31:0] model_read(int idx);
        int c, off;
        if (idx >= 12) return 32'h0;
        c = idx / 6;
        off = idx % 6;
        case (off)
            0: return m_cnt[c];
            1: return m_load[c];
            2: return m_bg[c];
            3: return {29'h0, m_ctrl[c]};
            4: return {31'h0, m_raw[c]};
            default: return {31'h0, m_raw[c] & m_ctrl[c][2]};
        endcase
    endfunction

    function automatic string tag_of(int idx);
        if (idx >= 12) return "R2";
        case (idx % 6)
            0: return "R12";
            1: return "R8";
            2: return "R9";
            3: return "R3";
            4: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_cnt[c] = '0; m_load[c] = '0; m_bg[c] = '0;
            m_ctrl[c] = '0; m_raw[c] = 1'b0; m_run[c] = 1'b0;
        end
    endtask

    task automatic model_step(bit wr, int idx, logic [31:0] wd);
        for (int c = 0; c < 2; c++) begin
            bit hit, expc, start, stop;
            int off;
            logic [31:0] sval;
            hit  = wr && idx >= c * 6 && idx < c * 6 + 6;
            off  = idx - c * 6;
            expc = m_run[c] && m_cnt[c] == 0;
            start = hit && ((off == 3 && wd[0]) || (off == 1 && m_ctrl[c][0]));
            stop  = hit && off == 3 && !wd[0];
            sval  = (off == 3) ? m_load[c] : wd;
            if (expc) m_raw[c] = 1'b1;
            if (start) begin
                m_cnt[c] = sval; m_run[c] = 1'b1;
            end else if (stop) begin
                m_run[c] = 1'b0;
            end else if (expc) begin
                if (m_ctrl[c][1]) m_run[c] = 1'b0;
                else m_cnt[c] = m_load[c];
            end else if (m_run[c]) begin
                m_cnt[c] = m_cnt[c] - 1;
            end
            if (hit) begin
                case (off)
                    1: m_load[c] = wd;
                    2: begin m_bg[c] = wd; m_load[c] = wd; end
                    3: m_ctrl[c] = wd[2:0];
                    4: if (wd[0] && !expc) m_raw[c] = 1'b0;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(bit rd, bit wr, logic [7:0] a, logic [31:0] wd, string tag);
        logic [31:0] exp;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        exp = model_read(int'(a[7:2]));
        model_step(wr, int'(a[7:2]), wd);
        #1;
        if (rd) check(tag, bus_rdata, exp);
        for (int c = 0; c < 2; c++)
            check("R11 irq", {31'h0, irq[c]}, {31'h0, m_raw[c] & m_ctrl[c][2]});
    endtask

    task automatic rd_word(int ch, int off, string tag);
        cyc(1'b1, 1'b0, adr(ch, off), 32'h0, tag);
    endtask

    task automatic wr_word(int ch, int off, logic [31:0] wd, string tag);
        cyc(1'b0, 1'b1, adr(ch, off), wd, tag);
    endtask

    initial begin
        int unsigned seed_val;
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 irq after reset", {30'h0, irq}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        // R1 / R2: every word zero after reset, reserved words zero
        for (int i = 0; i < 16; i++) cyc(1'b1, 1'b0, 8'(i * 4), 32'h0, "R1");

        // R3: only three control bits stored
        wr_word(0, 3, 32'hFFFF_FFFA, "R3");
        rd_word(0, 3, "R3");
        wr_word(0, 3, 32'h0, "R3");

        // R8 disabled load only stores; R4 start and stop; R5 decrement
        wr_word(0, 1, 32'd5, "R8");
        rd_word(0, 0, "R8");
        wr_word(0, 3, 32'h1, "R4");
        for (int i = 0; i < 4; i++) rd_word(0, 0, "R5");
        wr_word(0, 3, 32'h0, "R4");
        for (int i = 0; i < 3; i++) rd_word(0, 0, "R4");

        // R6 periodic expiry with interrupt enabled
        wr_word(0, 1, 32'd3, "R6");
        wr_word(0, 3, 32'h5, "R6");
        for (int i = 0; i < 10; i++) begin
            rd_word(0, 0, "R6");
            rd_word(0, 4, "R6");
        end
        rd_word(0, 5, "R11");

        // R10 write 0 keeps, write 1 clears
        wr_word(0, 3, 32'h4, "R10");
        wr_word(0, 4, 32'h0, "R10");
        rd_word(0, 4, "R10");
        wr_word(0, 4, 32'h1, "R10");
        rd_word(0, 4, "R10");
        rd_word(0, 5, "R11");

        // R9 background load while running
        wr_word(0, 1, 32'd6, "R9");
        wr_word(0, 3, 32'h1, "R9");
        wr_word(0, 2, 32'd2, "R9");
        for (int i = 0; i < 14; i++) rd_word(0, 0, "R9");
        rd_word(0, 1, "R9");
        rd_word(0, 2, "R9");

        // R7 one-shot on counter 1
        wr_word(1, 1, 32'd2, "R7");
        wr_word(1, 3, 32'h7, "R7");
        for (int i = 0; i < 8; i++) rd_word(1, 0, "R7");
        rd_word(1, 4, "R7");
        wr_word(1, 4, 32'h1, "R7");
        for (int i = 0; i < 3; i++) rd_word(1, 4, "R7");

        // R8 load write while enabled restarts
        wr_word(1, 1, 32'd4, "R8");
        for (int i = 0; i < 3; i++) rd_word(1, 0, "R8");

        // R12 value and masked words ignore writes
        wr_word(1, 0, 32'h1234, "R12");
        rd_word(1, 0, "R12");
        wr_word(1, 5, 32'hFFFF_FFFF, "R12");
        rd_word(1, 5, "R12");

        // R2 reserved writes ignored; R13 counter 0 untouched by counter 1 traffic
        for (int i = 12; i < 16; i++) cyc(1'b0, 1'b1, 8'(i * 4), 32'hFFFF_FFFF, "R2");
        for (int i = 0; i < 16; i++) cyc(1'b1, 1'b0, 8'(i * 4), 32'h0, "R13");

        // constrained random
        seed_val = $urandom(32'd2024);
        for (int n = 0; n < 4000; n++) begin
            int kind, idx, ch;
            kind = int'($urandom_range(0, 9));
            ch = int'($urandom_range(0, 1));
            idx = int'($urandom_range(0, 15));
            case (kind)
                0, 1, 2, 3: cyc(1'b1, 1'b0, 8'(idx * 4), 32'h0, tag_of(idx));
                4: wr_word(ch, 3, $urandom, "R4");
                5: wr_word(ch, 1, 32'($urandom_range(0, 12)), "R8");
                6: wr_word(ch, 2, 32'($urandom_range(0, 12)), "R9");
                7: wr_word(ch, 4, 32'($urandom_range(0, 1)), "R10");
                8: cyc(1'b0, 1'b1, 8'(({$urandom} % 2 == 0) ? adr(ch, 0) :
                       ({$urandom} % 2 == 0) ? adr(ch, 5) : 8'(idx * 4 | 48)),
                       $urandom, "R12");
                default: cyc(1'b0, 1'b0, 8'h0, 32'h0, "R5");
            endcase
        end
        for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 8'(i * 4), 32'h0, "R13");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule